// File: doc/BRIEF.md
# Double-to-Single Floating-Point Narrowing Converter

This block takes an IEEE-754 binary64 word and returns the nearest binary32 word under round-to-nearest, ties-to-even. A result is registered one clock after its input strobe. The datapath is split by the magnitude of the input. Values that fit the destination's normal range are rounded directly. Values that are too large saturate to infinity. NaNs keep as much of their payload as fits. Values below the destination's normal range are shifted into a subnormal with a sticky bit and then rounded, or they collapse to a signed zero.

All widths come from four parameters: the source and destination exponent and fraction widths. The same code can therefore narrow binary32 to binary16, or any other pair of interchange formats in which the destination is the narrower one. If the two exponent widths are equal, a shortcut copies words whose discarded fraction bits are all zero.

Top module: `fp_narrow`

## Requirements
- R1: Bit 31 of the result equals bit 63 of the input for every input class (normal, subnormal, zero, infinity, NaN).
- R2: `out_valid` goes high on the rising clock edge after a cycle in which `in_valid` was high, and low after a cycle in which it was low. `rst_n` low clears `out_valid` at once, without waiting for a clock edge.
- R3: If the input biased exponent e (bits 62:52) gives e − 1023 + 127 in the range 1..254, the result exponent is that value. The result fraction is input fraction bits 51:29. When bits 28:0 are greater than 2^28, the fraction is incremented.
- R4: When input fraction bits 28:0 equal exactly 2^28, the kept fraction is incremented only if its least significant bit (input bit 29) is 1. The same tie rule applies to the bits dropped on the subnormal path.
- R5: A rounding increment that overflows the 23-bit fraction carries into the exponent and leaves a zero fraction. Rounding up from 0x7F7FFFFF therefore gives infinity 0x7F800000.
- R6: A non-NaN input with e ≥ 1151, which includes input infinities, gives an all-ones exponent (0xFF) and a zero fraction.
- R7: An input with e = 0x7FF and a nonzero fraction gives exponent 0xFF, result bit 22 (quiet bit) set, and result bits 21:0 equal to input fraction bits 50:29.
- R8: For e ≤ 896 the significand {e≠0, fraction} is shifted right by 897 − max(e,1). Any 1 shifted out is ORed into bit 0. The kept bits then round as in R3/R4 with the exponent starting from 0. This produces subnormals down to 0x00000001.
- R9: Inputs with a shift above 53, double subnormals, and exact zeros give a zero of the input's sign.
- R10: A subnormal rounding carry out of the fraction gives the smallest normal 0x00800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release it in step with the clock |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 64 | binary64 operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | binary32 result, loaded when `in_valid` is high |

## Verification
Every result class, whether normal, carry, overflow, NaN, subnormal or zero, passes through the same single output register. Each one is therefore due exactly one rising edge after the cycle in which its operand is presented. The bench drives a new operand at every falling edge and compares the registered word at the next falling edge, half a period after the capturing edge. The reset check is different: it samples `out_valid` a fraction of a period after `rst_n` falls, with no clock edge in between, because that clear is asynchronous.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  // Which datapath produces the narrowed word
  typedef enum logic [1:0] {
    P_NORM = 2'd0,
    P_SUB  = 2'd1,
    P_NAN  = 2'd2,
    P_INF  = 2'd3
  } fpn_path_e;

endpackage

// File: rtl/fpn_classify.sv
module fpn_classify
  import fpn_pkg::*;
#(
  parameter int SE = 11,
  parameter int SF = 52,
  parameter int DE = 8,
  localparam int SHW = SE + 1
) (
  input  logic [SE-1:0]  exp_i,
  input  logic [SF-1:0]  frac_i,
  output fpn_path_e      path_o,
  output logic [DE-1:0]  dexp_o,
  output logic [SHW-1:0] shift_o
);

  localparam int SBIAS = (1 << (SE - 1)) - 1;
  localparam int DINF  = (1 << DE) - 1;
  localparam int DBIAS = DINF >> 1;
  localparam int OVF   = SBIAS + DINF - DBIAS;

  localparam logic signed [SE+1:0] C_REBIAS = (SE+2)'(SBIAS - DBIAS);
  localparam logic signed [SE+1:0] C_DINF   = (SE+2)'(DINF);
  localparam logic signed [SE+1:0] C_ONE    = (SE+2)'(1);
  localparam logic [SE-1:0]        C_OVF    = SE'(OVF);
  localparam logic [SHW-1:0]       C_SHBASE = SHW'(SBIAS - DBIAS + 1);

  logic signed [SE+1:0] cand;
  logic [SE-1:0]        exp_eff;
  logic                 is_nan;

  always_comb begin
    cand    = $signed({2'b00, exp_i}) - C_REBIAS;
    is_nan  = (&exp_i) && (|frac_i);
    exp_eff = (exp_i == '0) ? SE'(1) : exp_i;
    shift_o = C_SHBASE - {1'b0, exp_eff};
    dexp_o  = cand[DE-1:0];
    if (cand >= C_ONE && cand < C_DINF) begin
      path_o = P_NORM;
    end else if (is_nan) begin
      path_o = P_NAN;
    end else if (exp_i >= C_OVF) begin
      path_o = P_INF;
    end else begin
      path_o = P_SUB;
    end
  end

endmodule

// File: rtl/fpn_denorm.sv
module fpn_denorm #(
  parameter int SF  = 52,
  parameter int SHW = 12,
  localparam int SGW = SF + 1
) (
  input  logic [SGW-1:0] sig_i,
  input  logic [SHW-1:0] shift_i,
  output logic [SGW-1:0] sig_o
);

  localparam logic [SHW-1:0] C_SGW = SHW'(SGW);

  logic [SGW-1:0] lost_mask;
  logic           sticky;

  always_comb begin
    lost_mask = ~({SGW{1'b1}} << shift_i);
    sticky    = |(sig_i & lost_mask);
    if (shift_i > C_SGW) begin
      sig_o = '0;
    end else begin
      sig_o = (sig_i >> shift_i) | SGW'(sticky);
    end
  end

endmodule

// File: rtl/fpn_round.sv
module fpn_round #(
  parameter int EW = 8,
  parameter int FW = 23,
  parameter int TW = 29
) (
  input  logic [EW-1:0]    exp_i,
  input  logic [FW-1:0]    frac_i,
  input  logic [TW-1:0]    drop_i,
  output logic [EW+FW-1:0] word_o
);

  localparam logic [TW-1:0] C_HALF = TW'(1) << (TW - 1);

  logic bump;

  always_comb begin
    bump   = (drop_i > C_HALF) || ((drop_i == C_HALF) && frac_i[0]);
    // a fraction overflow ripples into the exponent field
    word_o = {exp_i, frac_i} + (EW+FW)'(bump);
  end

endmodule

// File: rtl/fp_narrow.sv
module fp_narrow
  import fpn_pkg::*;
#(
  parameter int SE = 11,
  parameter int SF = 52,
  parameter int DE = 8,
  parameter int DF = 23,
  localparam int SW   = 1 + SE + SF,
  localparam int DW   = 1 + DE + DF,
  localparam int TAIL = SF - DF,
  localparam int SHW  = SE + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  logic          in_sign;
  logic [SE-1:0] in_exp;
  logic [SF-1:0] in_frac;

  assign in_sign = in_data[SW-1];
  assign in_exp  = in_data[SW-2 -: SE];
  assign in_frac = in_data[SF-1:0];

  fpn_path_e      path;
  logic [DE-1:0]  dexp;
  logic [SHW-1:0] shift;

  fpn_classify #(.SE(SE), .SF(SF), .DE(DE)) u_class (
    .exp_i   (in_exp),
    .frac_i  (in_frac),
    .path_o  (path),
    .dexp_o  (dexp),
    .shift_o (shift)
  );

  logic [DE+DF-1:0] norm_word;

  fpn_round #(.EW(DE), .FW(DF), .TW(TAIL)) u_rnd_norm (
    .exp_i  (dexp),
    .frac_i (in_frac[SF-1 -: DF]),
    .drop_i (in_frac[TAIL-1:0]),
    .word_o (norm_word)
  );

  logic [SF:0] den;

  fpn_denorm #(.SF(SF), .SHW(SHW)) u_denorm (
    .sig_i   ({in_exp != '0, in_frac}),
    .shift_i (shift),
    .sig_o   (den)
  );

  logic [DE+DF-1:0] sub_word;

  fpn_round #(.EW(DE), .FW(DF), .TW(TAIL)) u_rnd_sub (
    .exp_i  ('0),
    .frac_i (den[SF-1 -: DF]),
    .drop_i (den[TAIL-1:0]),
    .word_o (sub_word)
  );

  logic          fast_hit;
  logic [DW-1:0] fast_word;

  generate
    if (SE == DE) begin : g_same_exp
      assign fast_hit  = (in_frac[TAIL-1:0] == '0);
      assign fast_word = {in_sign, in_exp, in_frac[SF-1 -: DF]};
    end else begin : g_wide_exp
      assign fast_hit  = 1'b0;
      assign fast_word = '0;
    end
  endgenerate

  logic [DW-1:0] res_d;
  logic [DW-1:0] res_q;
  logic          vld_q;

  always_comb begin
    unique case (path)
      P_NORM:  res_d = {in_sign, norm_word};
      P_SUB:   res_d = {in_sign, sub_word};
      P_NAN:   res_d = {in_sign, {DE{1'b1}}, 1'b1, in_frac[SF-2 -: DF-1]};
      default: res_d = {in_sign, {DE{1'b1}}, {DF{1'b0}}};
    endcase
    if (fast_hit) begin
      res_d = fast_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = res_q;

  // ---------------- assertions ----------------
  localparam int SBIAS_A = (1 << (SE - 1)) - 1;
  localparam int DINF_A  = (1 << DE) - 1;
  localparam logic [SE-1:0] A_OVF = SE'(SBIAS_A + DINF_A - (DINF_A >> 1));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r1_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data[DW-1] == $past(in_data[SW-1]));

  a_r6_overflow_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_exp >= A_OVF && !((&in_exp) && (|in_frac)))
    |=> (&out_data[DW-2 -: DE]) && (out_data[DF-1:0] == '0));

  a_r7_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (&in_exp) && (|in_frac))
    |=> (&out_data[DW-2 -: DE]) && out_data[DF-1]);

  a_r9_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_data[SW-2:0] == '0) |=> out_data[DW-2:0] == '0);

  a_r8_shift_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (path == P_SUB) |-> !den[SF]);

endmodule

// File: tb/fp_narrow_tb.sv
module fp_narrow_tb;

  localparam int CLK_P = 10;
  localparam int NV    = 32;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_data;
  logic        out_valid;
  logic [31:0] out_data;

  int checks;
  int errors;
  bit done;

  fp_narrow u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // {operand, expected result, requirement number}
  localparam logic [103:0] VECS [NV] = '{
    {64'h3FF0000000000000, 32'h3F800000, 8'd3},   // R3 1.0
    {64'hC004000000000000, 32'hC0200000, 8'd1},   // R1 -2.5
    {64'h3FF0000018000000, 32'h3F800001, 8'd3},   // R3 above half
    {64'h3FF000000FFFFFFF, 32'h3F800000, 8'd3},   // R3 below half
    {64'h3FF0000010000000, 32'h3F800000, 8'd4},   // R4 tie, even kept
    {64'h3FF0000030000000, 32'h3F800002, 8'd4},   // R4 tie, odd bumped
    {64'h3FF0000010000001, 32'h3F800001, 8'd3},   // R3 just above tie
    {64'h3FFFFFFFF0000000, 32'h40000000, 8'd5},   // R5 carry to 2.0
    {64'h47EFFFFFE0000000, 32'h7F7FFFFF, 8'd3},   // R3 max finite
    {64'h47EFFFFFEFFFFFFF, 32'h7F7FFFFF, 8'd3},   // R3 max finite, under half
    {64'h47EFFFFFF0000000, 32'h7F800000, 8'd5},   // R5 rounds to infinity
    {64'h47F0000000000000, 32'h7F800000, 8'd6},   // R6 overflow boundary
    {64'hC7F0000000000000, 32'hFF800000, 8'd6},   // R6 negative overflow
    {64'h7FF0000000000000, 32'h7F800000, 8'd6},   // R6 +inf
    {64'hFFF0000000000000, 32'hFF800000, 8'd6},   // R6 -inf
    {64'h7FF8000000000000, 32'h7FC00000, 8'd7},   // R7 quiet NaN
    {64'h7FF0000020000000, 32'h7FC00001, 8'd7},   // R7 signalling, payload bit
    {64'h7FF0000010000000, 32'h7FC00000, 8'd7},   // R7 payload fully dropped
    {64'hFFF4000000000000, 32'hFFE00000, 8'd7},   // R7 negative payload top
    {64'h0000000000000000, 32'h00000000, 8'd9},   // R9 +0
    {64'h8000000000000000, 32'h80000000, 8'd9},   // R9 -0
    {64'h3810000000000000, 32'h00800000, 8'd3},   // R3 smallest normal
    {64'h3800000000000000, 32'h00400000, 8'd8},   // R8 2^-127
    {64'h36A0000000000000, 32'h00000001, 8'd8},   // R8 smallest subnormal
    {64'h3690000000000000, 32'h00000000, 8'd8},   // R8 tie to even zero
    {64'h3690000000000001, 32'h00000001, 8'd8},   // R8 sticky breaks tie
    {64'h36A8000000000000, 32'h00000002, 8'd8},   // R8 tie, odd bumped
    {64'hB6A0000000000000, 32'h80000001, 8'd1},   // R1 negative subnormal
    {64'h3370000000000000, 32'h00000000, 8'd9},   // R9 far underflow
    {64'hB370000000000000, 32'h80000000, 8'd9},   // R9 negative underflow
    {64'h0000000000000001, 32'h00000000, 8'd9},   // R9 source subnormal
    {64'h380FFFFFE0000000, 32'h00800000, 8'd10}   // R10 subnormal carry
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (2) @(negedge clk);
    check("R2 reset out_valid", 32'(out_valid), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_data  = VECS[i][103:40];
      @(negedge clk);
      check("R2 valid follows", 32'(out_valid), 32'd1);
      check($sformatf("R%0d vector %0d", VECS[i][7:0], i), out_data, VECS[i][39:8]);
    end

    in_valid = 1'b0;
    @(negedge clk);
    check("R2 idle clears valid", 32'(out_valid), 32'd0);

    in_valid = 1'b1;
    in_data  = 64'h3FF0000000000000;
    @(negedge clk);
    check("R2 valid again", 32'(out_valid), 32'd1);
    #(CLK_P/4);
    rst_n = 1'b0;
    #1;
    check("R2 async clear", 32'(out_valid), 32'd0);
    @(negedge clk);
    rst_n    = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule